// File: doc/BRIEF.md
# Sensor Node Power Mode Controller

This block sequences a three-part sensor node (sensing, computation, communication) between a full-power active mode and two low-power modes. It drives one registered run-enable for each part. The computation side asks for a mode change through a small strobed command port. Once the node is in a low-power mode, only an internal countdown timer can bring it back to active.

The two low-power modes differ in what they keep running. In sleep, sensing and computation stop, but communication keeps running so the node can still pass on traffic from its neighbours. Each relay event seen in sleep restarts the countdown, so a node that is busy forwarding stays asleep. In idle, all three parts stop and only the timer runs. When the countdown ends, the block raises a one-cycle wake pulse, returns to active and turns all enables back on.

Top module: `node_pwr_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the mode output is 00 (active), all three enables are 1 and the wake pulse is 0.
- R2: In active mode, a strobed request with code 01 moves the mode output to 01 (sleep) and code 10 moves it to 10 (idle), one clock after the strobe.
- R3: A request with code 11 is ignored, and code 00 in active mode leaves the mode unchanged.
- R4: Any request, of any code, arriving while the mode is sleep or idle is dropped, and the mode stays unchanged.
- R5: In sleep, the enables are sense=0, compute=0, communication=1 (enable bus bit 0 = sense, bit 1 = compute, bit 2 = communication).
- R6: In idle, all three enables are 0.
- R7: The enable bus reflects the mode exactly one clock after the mode output changes. No enable changes in any other cycle.
- R8: The wake period input is sampled in the cycle a low-power request is accepted. With period P, the mode output stays in the low-power mode for P+1 cycles and then returns to 00. Changes to the period input during the stay have no effect unless a relay restart occurs.
- R9: A relay event during sleep reloads the countdown from the current period input, and takes priority over expiry. A relay event has no effect in idle or active.
- R10: The wake pulse is high for exactly one cycle, in the first cycle the mode output is back at 00 after a timed wake, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_code | input | 2 | Requested mode: 00 active, 01 sleep, 10 idle, 11 reserved |
| wake_period | input | TIMER_W | Countdown length for low-power stays |
| relay_evt | input | 1 | Relay traffic seen by the communication part |
| en_sense | output | 1 | Run-enable of the sensing part |
| en_comp | output | 1 | Run-enable of the computation part |
| en_comm | output | 1 | Run-enable of the communication part |
| mode | output | 2 | Current mode, same encoding as req_code |
| wake_pulse | output | 1 | One-cycle pulse on a timed return to active |

## Verification
The hardest situation to reach is a relay restart that lands in the final low-power cycle, where the counter is already zero and expiry would otherwise win. It is also hard to combine a restart with a period input that changed after entry. The bench enters sleep with a small period, changes the period at once, and asserts the relay on a chosen cycle of the stay, including the last one. It then measures the stay length in cycles and compares it with the length computed from the relay position and the new period. The same sweep injects every request code partway through both low-power modes.

// File: rtl/pwr_ctrl_pkg.sv
// Shared types for the sensor node power mode controller.
// Assumes three controlled domains in a fixed bit order on the enable bus.
package pwr_ctrl_pkg;
    localparam int NUM_DOM   = 3;
    localparam int DOM_SENSE = 0;
    localparam int DOM_COMP  = 1;
    localparam int DOM_COMM  = 2;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'b00,
        MODE_SLEEP  = 2'b01,
        MODE_IDLE   = 2'b10
    } pwr_mode_e;

    // Enable pattern each mode calls for.
    function automatic logic [NUM_DOM-1:0] dom_mask(input pwr_mode_e m);
        logic [NUM_DOM-1:0] r;
        r = '1;
        case (m)
            MODE_SLEEP: begin
                r            = '0;
                r[DOM_COMM]  = 1'b1;
            end
            MODE_IDLE:  r = '0;
            default:    r = '1;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pwr_req_filter.sv
// Request qualifier: turns a strobed mode code into entry commands.
// Entry is allowed only from active mode; reserved and redundant codes
// produce nothing. Purely combinational; clk/rst_n are for checks only.
module pwr_req_filter
    import pwr_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic [1:0] req_code,
    input  pwr_mode_e cur_mode,
    output logic      go_sleep,
    output logic      go_idle
);
    logic in_active;

    // Decode the request against the present mode.
    always_comb begin
        in_active = (cur_mode == MODE_ACTIVE);
        go_sleep  = req_valid && in_active && (req_code == 2'b01);
        go_idle   = req_valid && in_active && (req_code == 2'b10);
    end

    // R4: nothing is accepted once in a low-power mode
    a_r4_drop_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != MODE_ACTIVE) |-> !(go_sleep || go_idle));

    // R3: reserved code never starts a transition
    a_r3_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        (req_code == 2'b11) |-> !(go_sleep || go_idle));
endmodule

// File: rtl/pwr_wake_timer.sv
// Wake countdown. Loaded from the period input on low-power entry or on a
// restart, counts down while running and flags expiry at zero.
// Assumes load is only raised from active mode; restart beats expiry.
module pwr_wake_timer #(
    parameter int TIMER_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               restart,
    input  logic               run,
    input  logic [TIMER_W-1:0] period,
    output logic               expire
);
    logic [TIMER_W-1:0] cnt_q;

    // Countdown register with reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load || restart)
            cnt_q <= period;
        else if (run && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    // Expiry flag for the mode state machine.
    always_comb expire = run && !restart && (cnt_q == '0);

    // R8: reload takes the sampled period
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (load || restart) |=> (cnt_q == $past(period)));

    // R8: one step per running cycle
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !restart && (cnt_q != '0)) |=>
        (cnt_q == $past(cnt_q) - 1'b1));

    // R9: restart suppresses expiry
    a_r9_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !expire);
endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode state machine: active, sleep, idle. Leaves a low-power mode only
// on timer expiry and then emits a one-cycle wake pulse.
// Assumes entry commands are already filtered to active mode.
module pwr_mode_fsm
    import pwr_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go_sleep,
    input  logic      go_idle,
    input  logic      expire,
    output pwr_mode_e mode_q,
    output logic      wake_q
);
    pwr_mode_e mode_d;

    // Next-mode selection.
    always_comb begin
        mode_d = mode_q;
        if (go_sleep)      mode_d = MODE_SLEEP;
        else if (go_idle)  mode_d = MODE_IDLE;
        else if (expire)   mode_d = MODE_ACTIVE;
    end

    // Mode and wake pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_ACTIVE;
            wake_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            wake_q <= expire;
        end
    end

    // R4: low-power mode held until the timer ends it
    a_r4_hold_lp: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_ACTIVE && !expire) |=> (mode_q == $past(mode_q)));

    // R2: accepted sleep request lands next cycle
    a_r2_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        go_sleep |=> (mode_q == MODE_SLEEP));

    // R10: pulse lasts one cycle
    a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q);

    // R10: pulse only on a return to active
    a_r10_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> (mode_q == MODE_ACTIVE && $past(mode_q) != MODE_ACTIVE));
endmodule

// File: rtl/pwr_en_bank.sv
// Registered enable bank, one flop per domain, each following the mode
// one clock late so no enable can glitch. Reset turns every domain on.
module pwr_en_bank
    import pwr_ctrl_pkg::*;
#(
    parameter int N = NUM_DOM
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pwr_mode_e mode,
    output logic [N-1:0] en_q
);
    logic [NUM_DOM-1:0] mask;

    // Target pattern for the present mode.
    always_comb mask = dom_mask(mode);

    for (genvar i = 0; i < N; i++) begin : g_dom
        // One enable flop per domain.
        always_ff @(posedge clk) begin
            if (!rst_n) en_q[i] <= 1'b1;
            else        en_q[i] <= mask[i];
        end
    end

    // R7: enables move only after a mode change
    a_r7_no_stray_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> ($past(mode) != $past(mode, 2)));

    // R5: sleep pattern one clock after sleep
    a_r5_sleep_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_SLEEP) |-> (en_q == 3'b100));

    // R6: idle pattern one clock after idle
    a_r6_idle_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_IDLE) |-> (en_q == 3'b000));
endmodule

// File: rtl/node_pwr_ctrl.sv
// Top of the sensor node power mode controller. Filters requests, runs the
// mode machine and wake timer, and drives three registered enables.
// Assumes relay_evt and req_* are synchronous to clk.
module node_pwr_ctrl
    import pwr_ctrl_pkg::*;
#(
    parameter int TIMER_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_code,
    input  logic [TIMER_W-1:0] wake_period,
    input  logic               relay_evt,
    output logic               en_sense,
    output logic               en_comp,
    output logic               en_comm,
    output logic [1:0]         mode,
    output logic               wake_pulse
);
    pwr_mode_e          mode_q;
    logic               go_sleep, go_idle, expire, wake_q;
    logic               tmr_load, tmr_restart, tmr_run;
    logic [NUM_DOM-1:0] en_q;

    pwr_req_filter u_filter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .cur_mode(mode_q), .go_sleep(go_sleep), .go_idle(go_idle)
    );

    // Timer control derived from the mode.
    always_comb begin
        tmr_load    = go_sleep || go_idle;
        tmr_restart = relay_evt && (mode_q == MODE_SLEEP);
        tmr_run     = (mode_q != MODE_ACTIVE);
    end

    pwr_wake_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .restart(tmr_restart),
        .run(tmr_run), .period(wake_period), .expire(expire)
    );

    pwr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go_sleep(go_sleep), .go_idle(go_idle),
        .expire(expire), .mode_q(mode_q), .wake_q(wake_q)
    );

    pwr_en_bank #(.N(NUM_DOM)) u_en (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .en_q(en_q)
    );

    // Output mapping.
    always_comb begin
        en_sense   = en_q[DOM_SENSE];
        en_comp    = en_q[DOM_COMP];
        en_comm    = en_q[DOM_COMM];
        mode       = mode_q;
        wake_pulse = wake_q;
    end

    // R1: first cycle out of reset is fully active
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (mode == 2'b00 && en_sense && en_comp && en_comm && !wake_pulse));
endmodule

// File: tb/node_pwr_ctrl_tb_top.sv
// Sweep bench for node_pwr_ctrl: stay lengths computed from period, relay
// position and period changes; enables and pulse checked every cycle.
module node_pwr_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_code = 2'b00;
    logic [23:0] wake_period = '0;
    logic        relay_evt = 1'b0;
    logic        en_sense, en_comp, en_comm, wake_pulse;
    logic [1:0]  mode;
    logic [2:0]  en;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    node_pwr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .wake_period(wake_period), .relay_evt(relay_evt), .en_sense(en_sense),
        .en_comp(en_comp), .en_comm(en_comm), .mode(mode), .wake_pulse(wake_pulse)
    );

    assign en = {en_comm, en_comp, en_sense};

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: act %0d cycles exp <150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    // Enter a low-power mode and follow it until the return to active.
    task automatic lp_run(input logic [1:0] code, input int p, input int p2,
                          input int relay_at, input int req_at,
                          input logic [1:0] rcode, input string tag);
        int expn;
        int n;
        logic [2:0] lpm;
        lpm  = (code == 2'b01) ? 3'b100 : 3'b000;
        expn = (code == 2'b01 && relay_at > 0) ? relay_at + p2 + 1 : p + 1;
        wake_period = p[23:0];
        req_valid = 1'b1;
        req_code  = code;
        tick;
        req_valid = 1'b0;
        wake_period = p2[23:0];
        chk(mode == code, "R2", "mode after request", mode, code);
        chk(en == 3'b111, "R7", "enables in entry cycle", en, 7);
        n = 1;
        for (int it = 0; it < 2000; it++) begin
            relay_evt = (n == relay_at);
            req_valid = (n == req_at);
            req_code  = rcode;
            tick;
            relay_evt = 1'b0;
            req_valid = 1'b0;
            if (mode == 2'b00) break;
            n++;
            chk(mode == code, "R4", "mode held in low power", mode, code);
            chk(en == lpm, (code == 2'b01) ? "R5" : "R6", "low-power enables", en, lpm);
            chk(!wake_pulse, "R10", "no pulse during stay", wake_pulse, 0);
        end
        chk(n == expn, tag, "low-power stay length", n, expn);
        chk(wake_pulse == 1'b1, "R10", "pulse on return", wake_pulse, 1);
        chk(en == lpm, "R7", "enables lag the return", en, lpm);
        tick;
        chk(en == 3'b111, "R7", "enables back on", en, 7);
        chk(!wake_pulse, "R10", "pulse ends", wake_pulse, 0);
        chk(mode == 2'b00, "R8", "stays active", mode, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) tick;
        chk(mode == 2'b00 && en == 3'b111 && !wake_pulse, "R1", "state in reset", {mode, en}, 7);
        rst_n = 1'b1;
        tick;
        chk(mode == 2'b00, "R1", "mode after reset", mode, 0);
        chk(en == 3'b111, "R1", "enables after reset", en, 7);
        chk(!wake_pulse, "R1", "pulse after reset", wake_pulse, 0);

        // R3: codes 00 and 11 in active change nothing
        for (int rc = 0; rc < 4; rc += 3) begin
            req_valid = 1'b1;
            req_code = rc[1:0];
            tick;
            req_valid = 1'b0;
            chk(mode == 2'b00, "R3", "mode after no-op code", mode, 0);
            tick;
            chk(en == 3'b111, "R3", "enables after no-op code", en, 7);
        end

        // R9: relay in active has no effect
        relay_evt = 1'b1;
        tick;
        relay_evt = 1'b0;
        tick;
        chk(mode == 2'b00 && !wake_pulse && en == 3'b111, "R9", "relay in active", mode, 0);

        // R8: period sweep for both low-power modes
        for (int c = 1; c <= 2; c++)
            for (int p = 0; p <= 7; p++)
                lp_run(c[1:0], p, p, 0, 0, 2'b00, "R8");

        // R8: period change during the stay is ignored without restart
        lp_run(2'b01, 4, 1, 0, 0, 2'b00, "R8");
        lp_run(2'b10, 3, 9, 0, 0, 2'b00, "R8");

        // R9: relay restarts in sleep, including the last cycle of the stay
        for (int r = 1; r <= 4; r++)
            lp_run(2'b01, 3, 3, r, 0, 2'b00, "R9");
        lp_run(2'b01, 4, 1, 2, 0, 2'b00, "R9");
        lp_run(2'b01, 2, 5, 3, 0, 2'b00, "R9");
        lp_run(2'b01, 0, 0, 1, 0, 2'b00, "R9");

        // R9: relay in idle is ignored
        lp_run(2'b10, 3, 3, 2, 0, 2'b00, "R9");

        // R4: every request code dropped in both low-power modes
        for (int c = 1; c <= 2; c++)
            for (int rc = 0; rc < 4; rc++)
                lp_run(c[1:0], 4, 4, 0, 2, rc[1:0], "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule